// File: doc/BRIEF.md
# Group Slice Sequencer

This block runs one instruction for a group of 64 work items on an execution datapath that has only 16 lanes. Once an instruction has been accepted with a mask that marks which items are valid, the block presents one quarter of the group on each of four consecutive clocks. Each clock it drives a slice number and the 16-bit lane mask for that quarter toward the execution units.

With each slice the block also reports how many multiply-adds it will do. This is the number of active lanes times the number of filled slots in the instruction's bundle. A one-cycle completion pulse follows the last quarter.

The issue side uses a valid/ready handshake. Ready comes back during the final quarter, so an issuer that always has work keeps the lanes busy every clock. A quarter whose mask is all zero still takes its clock, so every instruction takes exactly four cycles.

Top module: `group_slice_seq`

## Requirements
- R1: While reset is asserted and after it is released, `issue_ready_o` is 1, `slice_valid_o` is 0 and `done_o` is 0 until the first accepted issue.
- R2: An issue is accepted on a clock edge where `issue_valid_i` and `issue_ready_o` are both 1. On the four cycles after that edge, `slice_valid_o` is 1 and `slice_idx_o` reads 0, 1, 2, 3 in that order.
- R3: During slice k, `slice_mask_o` bit j equals item mask bit 16*k+j. Slice 0 carries items 0 to 15 and slice 3 carries items 48 to 63.
- R4: A slice whose 16 mask bits are all zero is still presented for its own cycle with `slice_valid_o` at 1. The sequence stays exactly four cycles long.
- R5: `issue_ready_o` is 0 while slices 0, 1 and 2 are presented, and 1 during slice 3 and when idle. An `issue_valid_i` seen while ready is 0 has no effect on the slices presented and adds no slices.
- R6: An issue accepted during slice 3 starts its slice 0 on the very next cycle. Back-to-back instructions form an unbroken run of valid slices with none lost or repeated.
- R7: `done_o` is 1 for exactly one cycle, the cycle after slice 3 is presented, and is 0 otherwise.
- R8: `slice_ops_o` equals the number of ones in `slice_mask_o` times the bundle slot count captured at issue. A slot count of 0 is taken as 1 and a count above 4 is taken as 4. `slice_last_o` is 1 only during slice 3.
- R9: When `slice_valid_o` is 0, `slice_mask_o` and `slice_ops_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid_i | input | 1 | An instruction is offered |
| issue_ready_o | output | 1 | The block can accept an instruction this cycle |
| issue_mask_i | input | 64 | Valid flag per item of the group, bit i for item i |
| issue_slots_i | input | 3 | Filled slots in the instruction bundle (1 to 4) |
| slice_valid_o | output | 1 | A quarter of the group is presented this cycle |
| slice_idx_o | output | 2 | Number of the quarter presented |
| slice_mask_o | output | 16 | Lane mask of the quarter presented |
| slice_ops_o | output | 7 | Multiply-adds done by the quarter presented |
| slice_last_o | output | 1 | The quarter presented is the final one |
| done_o | output | 1 | One-cycle pulse after the final quarter |

## Verification
The bench builds the block with its default values: 64 items, 16 lanes and at most 4 bundle slots. With these values the quarter boundaries at items 16, 32 and 48 can be checked exactly, along with the clamping of slot counts 0 and 7. Masks with empty quarters show that the cycle count stays fixed. A held issue valid across three instructions puts an acceptance inside the final quarter, which tests the seamless hand-over and shows that offers made while ready is low are ignored.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/sgs_rst_sync.sv
module sgs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sgs_step_ctrl.sv
module sgs_step_ctrl
  import sgs_pkg::*;
#(
  parameter  int unsigned NUM_SLICES = 4,
  localparam int unsigned IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid_i,
  output logic             issue_ready_o,
  output logic             accept_o,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLICES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             at_last;
  logic             step_en;

  assign at_last       = (state_q == SEQ_RUN) && (idx_q == LAST_IDX);
  assign issue_ready_o = (state_q == SEQ_IDLE) || at_last;
  assign accept_o      = issue_valid_i && issue_ready_o;
  assign step_en       = accept_o || (state_q == SEQ_RUN);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = at_last;
    if (accept_o) begin
      state_d = SEQ_RUN;
      idx_d   = '0;
    end else if (state_q == SEQ_RUN) begin
      if (at_last) begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        state_q <= state_d;
        idx_q   <= idx_d;
      end
    end
  end

  assign run_o  = (state_q == SEQ_RUN);
  assign idx_o  = idx_q;
  assign last_o = at_last;
  assign done_o = done_q;

  // R2
  slice_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_o) |=> (run_o && idx_o == $past(idx_o) + 1'b1));

  // R6
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (run_o && idx_o == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_o));

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_o) |-> !accept_o);

endmodule

// File: rtl/sgs_slice_store.sv
module sgs_slice_store #(
  parameter  int unsigned GROUP_ITEMS = 64,
  parameter  int unsigned LANES       = 16,
  parameter  int unsigned MAX_SLOTS   = 4,
  localparam int unsigned NUM_SLICES  = GROUP_ITEMS / LANES,
  localparam int unsigned IDX_W       = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [GROUP_ITEMS-1:0] mask_i,
  input  logic [SLOT_W-1:0]      slots_i,
  input  logic                   run_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [LANES-1:0]       slice_mask_o,
  output logic [SLOT_W-1:0]      slots_o
);

  logic [GROUP_ITEMS-1:0] mask_q;
  logic [SLOT_W-1:0]      slots_q;
  logic [SLOT_W-1:0]      slots_fit;
  logic [LANES-1:0]       part [NUM_SLICES];

  always_comb begin
    if (slots_i == '0) begin
      slots_fit = SLOT_W'(1);
    end else if (slots_i > SLOT_W'(MAX_SLOTS)) begin
      slots_fit = SLOT_W'(MAX_SLOTS);
    end else begin
      slots_fit = slots_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      slots_q <= '0;
    end else if (load_i) begin
      mask_q  <= mask_i;
      slots_q <= slots_fit;
    end
  end

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_part
    assign part[g] = mask_q[g*LANES +: LANES];
  end

  assign slice_mask_o = run_i ? part[idx_i] : '0;
  assign slots_o      = slots_q;

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mask_q == $past(mask_i)));

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (slots_q != '0 && slots_q <= SLOT_W'(MAX_SLOTS)));

endmodule

// File: rtl/group_slice_seq.sv
module group_slice_seq #(
  parameter  int unsigned GROUP_ITEMS = 64,
  parameter  int unsigned LANES       = 16,
  parameter  int unsigned MAX_SLOTS   = 4,
  localparam int unsigned NUM_SLICES  = GROUP_ITEMS / LANES,
  localparam int unsigned IDX_W       = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1),
  localparam int unsigned OPS_W       = $clog2(LANES * MAX_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid_i,
  output logic                   issue_ready_o,
  input  logic [GROUP_ITEMS-1:0] issue_mask_i,
  input  logic [SLOT_W-1:0]      issue_slots_i,
  output logic                   slice_valid_o,
  output logic [IDX_W-1:0]       slice_idx_o,
  output logic [LANES-1:0]       slice_mask_o,
  output logic [OPS_W-1:0]       slice_ops_o,
  output logic                   slice_last_o,
  output logic                   done_o
);

  localparam int unsigned CNT_W = $clog2(LANES + 1);

  logic              rst_n_sync;
  logic              accept;
  logic [SLOT_W-1:0] slots_q;
  logic [CNT_W-1:0]  lane_cnt;

  sgs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  sgs_step_ctrl #(.NUM_SLICES(NUM_SLICES)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .issue_valid_i (issue_valid_i),
    .issue_ready_o (issue_ready_o),
    .accept_o      (accept),
    .run_o         (slice_valid_o),
    .idx_o         (slice_idx_o),
    .last_o        (slice_last_o),
    .done_o        (done_o)
  );

  sgs_slice_store #(
    .GROUP_ITEMS (GROUP_ITEMS),
    .LANES       (LANES),
    .MAX_SLOTS   (MAX_SLOTS)
  ) i_store (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .load_i       (accept),
    .mask_i       (issue_mask_i),
    .slots_i      (issue_slots_i),
    .run_i        (slice_valid_o),
    .idx_i        (slice_idx_o),
    .slice_mask_o (slice_mask_o),
    .slots_o      (slots_q)
  );

  always_comb begin
    lane_cnt = '0;
    for (int unsigned l = 0; l < LANES; l++) begin
      lane_cnt = lane_cnt + CNT_W'(slice_mask_o[l]);
    end
  end

  assign slice_ops_o = OPS_W'(lane_cnt) * OPS_W'(slots_q);

  // R4
  fixed_length_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (slice_valid_o && !slice_last_o) |=> slice_valid_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !slice_valid_o |-> (slice_mask_o == '0 && slice_ops_o == '0));

  // R8
  empty_ops_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (slice_valid_o && slice_mask_o == '0) |-> slice_ops_o == '0);

endmodule

// File: tb/test_group_slice_seq.sv
module test_group_slice_seq;

  typedef struct {
    logic [1:0]  idx;
    logic [15:0] mask;
    logic [6:0]  ops;
    logic        last;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [63:0] issue_mask;
  logic [2:0]  issue_slots;
  logic        slice_valid;
  logic [1:0]  slice_idx;
  logic [15:0] slice_mask;
  logic [6:0]  slice_ops;
  logic        slice_last;
  logic        done;

  int   total = 0;
  int   bad   = 0;
  bit   mon_en = 1'b0;
  bit   prev_last = 1'b0;
  int   run_len = 0;
  int   run_max = 0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  group_slice_seq i_group_slice_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid_i (issue_valid),
    .issue_ready_o (issue_ready),
    .issue_mask_i  (issue_mask),
    .issue_slots_i (issue_slots),
    .slice_valid_o (slice_valid),
    .slice_idx_o   (slice_idx),
    .slice_mask_o  (slice_mask),
    .slice_ops_o   (slice_ops),
    .slice_last_o  (slice_last),
    .done_o        (done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int popc16(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic issue(input logic [63:0] m, input logic [2:0] s);
    int cs;
    @(negedge clk);
    issue_valid = 1'b1;
    issue_mask  = m;
    issue_slots = s;
    while (!issue_ready) @(negedge clk);
    cs = (s == 3'd0) ? 1 : ((s > 3'd4) ? 4 : int'(s));
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.idx  = 2'(k);
      e.mask = m[k*16 +: 16];
      e.ops  = 7'(popc16(m[k*16 +: 16]) * cs);
      e.last = (k == 3);
      exp_q.push_back(e);
    end
    @(posedge clk);
  endtask

  task automatic go_idle(input int cycles);
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor: scoreboard pop and per-cycle port relations
  always @(negedge clk) begin
    if (mon_en) begin
      // R5 ready low on slices 0..2, high on slice 3 and idle
      chk(issue_ready == (!slice_valid || slice_last), "R5", issue_ready, !slice_valid || slice_last);
      // R7 done one cycle after final slice
      chk(done == prev_last, "R7", done, prev_last);
      if (slice_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 extra slice", slice_idx, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(slice_idx == e.idx, "R2 idx", slice_idx, e.idx);
          chk(slice_mask == e.mask, "R3 mask", slice_mask, e.mask);
          chk(slice_ops == e.ops, "R8 ops", slice_ops, e.ops);
          chk(slice_last == e.last, "R8 last", slice_last, e.last);
        end
        run_len++;
        if (run_len > run_max) run_max = run_len;
      end else begin
        // R9 quiet outputs when idle
        chk(slice_mask == 16'h0 && slice_ops == 7'h0, "R9", {slice_mask, slice_ops}, 0);
        run_len = 0;
      end
      prev_last = slice_valid && slice_last;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    issue_valid = 1'b0;
    issue_mask  = '0;
    issue_slots = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(issue_ready == 1'b1, "R1 ready", issue_ready, 1);
    chk(slice_valid == 1'b0, "R1 valid", slice_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(issue_ready == 1'b1 && slice_valid == 1'b0 && done == 1'b0, "R1 after release",
        {issue_ready, slice_valid, done}, 3'b100);
    mon_en = 1'b1;

    // R2 R3 single issue, slice 2 empty (R4)
    issue(64'hF0F0_0000_0001_8000, 3'd4);
    go_idle(6);

    // R4 only one non-empty quarter
    issue(64'h0000_00FF_0000_0000, 3'd2);
    go_idle(6);

    // R8 slot clamping: 0 -> 1, 7 -> 4
    issue(64'h8421_8421_8421_8421, 3'd0);
    go_idle(2);
    issue(64'hFFFF_FFFF_FFFF_FFFF, 3'd7);
    go_idle(6);

    // R6 back-to-back with valid held, offers while busy ignored (R5)
    run_max = 0;
    issue(64'h1111_2222_3333_4444, 3'd1);
    issue(64'h0000_0000_0000_0000, 3'd3);
    issue(64'hAAAA_5555_FFFF_0001, 3'd2);
    go_idle(8);
    chk(run_max >= 12, "R6 unbroken run", run_max, 12);
    chk(exp_q.size() == 0, "R2 all slices seen", exp_q.size(), 0);

    mon_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule